// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves the control-flow outcome of one jump-class operation per cycle. It is handed the program counter of the operation (counted in 64-bit instruction words), a 4-bit condition code, a left operand, a right operand that is either a register value or a sign-extended 32-bit immediate, and a displacement. It reports whether the jump is taken and which instruction word runs next.

Comparisons can be made on the full 64-bit operands or on their low 32 bits only. Displacements are signed and count instruction words relative to the word after the current one. An end-of-program code raises a sticky halt output and freezes the program counter until reset. All results are registered: a request presented with `req_valid` on one rising edge is answered on the outputs for the following cycle.

Top module: `brx_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outputs are cleared to zero on that edge.
- R2: A request sampled with `req_valid` high (and not halted) gives `res_valid` high for exactly the next cycle; a cycle without a request gives `res_valid` and `taken` low and leaves `next_pc` unchanged.
- R3: Condition codes: 0 short jump (always taken), 1 long jump (always taken), 2 taken when operands are equal, 3 taken when they differ; codes 14 and 15 are never taken.
- R4: Codes 4, 5, 6, 7 take the jump when the left operand is, as unsigned numbers, greater than, greater or equal to, less than, or less than or equal to the right operand.
- R5: Codes 8, 9, 10, 11 do the same four comparisons on two's-complement signed values.
- R6: Code 12 is taken exactly when the bitwise AND of the two operands is nonzero.
- R7: With `use_imm` high the right operand is `imm` sign-extended to 64 bits; with it low it is `rhs_reg`.
- R8: With `cmp_narrow` high only bits 31:0 of both operands are compared, bit 31 being the sign for codes 8 to 11; upper bits have no effect.
- R9: A taken jump other than code 1 yields `cur_pc + 1 + sext(disp[15:0])` (modulo 2^64), ignoring `disp[31:16]`; any jump not taken yields `cur_pc + 1`.
- R10: A taken code 1 yields `cur_pc + 1 + sext(disp[31:0])`.
- R11: Code 13 sets `halted`, returns `taken` low and `next_pc = cur_pc`; once halted, the unit stays halted and ignores requests until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| cur_pc | input | 64 | Word address of the jump operation |
| cond | input | 4 | Condition code (see R3 to R6, R11) |
| lhs | input | 64 | Left compare operand |
| rhs_reg | input | 64 | Right operand, register form |
| imm | input | 32 | Right operand, immediate form |
| use_imm | input | 1 | Select immediate as right operand |
| cmp_narrow | input | 1 | Compare low 32 bits only |
| disp | input | 32 | Signed word displacement |
| res_valid | output | 1 | Result valid this cycle |
| taken | output | 1 | Jump taken |
| next_pc | output | 64 | Word address to run next |
| halted | output | 1 | End of program reached |

## Verification
The bench aims at operand pairs whose signed and unsigned orderings disagree (all-ones against one, bit 63 or bit 31 set), so a unit that shared one comparator between both families would take the wrong branch. Narrow-mode cases use operands equal in their low half but different above it; a unit leaking upper bits would fail them. Negative and upper-half-polluted displacements catch wrong sign extension or a short jump that used the long field, and requests after the end code catch a halt that is not sticky or that still moves the program counter.

// File: rtl/brx_pkg.sv
// Shared types of the branch resolution unit.
// Assumes: condition codes are 4 bits; values 14 and 15 are reserved.
package brx_pkg;

    localparam int BRC_W = 4;

    typedef enum logic [BRC_W-1:0] {
        BC_JMP  = 4'd0,
        BC_JMPL = 4'd1,
        BC_EQ   = 4'd2,
        BC_NE   = 4'd3,
        BC_UGT  = 4'd4,
        BC_UGE  = 4'd5,
        BC_ULT  = 4'd6,
        BC_ULE  = 4'd7,
        BC_SGT  = 4'd8,
        BC_SGE  = 4'd9,
        BC_SLT  = 4'd10,
        BC_SLE  = 4'd11,
        BC_BTST = 4'd12,
        BC_EXIT = 4'd13
    } brc_e;

    typedef struct packed {
        logic eq;
        logic ltu;
        logic lts;
        logic anybit;
    } cmp_flags_t;

endpackage

// File: rtl/brx_operand_mux.sv
// Right-operand selector: picks the register value or the sign-extended immediate.
// Assumes: IMM_W < DATA_W.
module brx_operand_mux #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [DATA_W-1:0] rhs_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    output logic [DATA_W-1:0] rhs
);
    localparam int EXT_W = DATA_W - IMM_W;

    // choose source of the right operand
    always_comb begin
        if (use_imm) rhs = {{EXT_W{imm[IMM_W-1]}}, imm};
        else         rhs = rhs_reg;
    end
endmodule

// File: rtl/brx_comparator.sv
// Comparator: equality, unsigned-less, signed-less and bit-overlap flags,
// on the full width or on the low NARROW_W bits.
// Assumes: NARROW_W <= DATA_W.
module brx_comparator
    import brx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              narrow,
    output cmp_flags_t        flags
);
    localparam logic [DATA_W-1:0]   W_SIGN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [NARROW_W-1:0] N_SIGN = {1'b1, {(NARROW_W-1){1'b0}}};

    cmp_flags_t wide_f;
    cmp_flags_t narrow_f;

    // full-width flags; signed order via sign-bit flip
    always_comb begin
        wide_f.eq     = (lhs == rhs);
        wide_f.ltu    = (lhs < rhs);
        wide_f.lts    = ((lhs ^ W_SIGN) < (rhs ^ W_SIGN));
        wide_f.anybit = |(lhs & rhs);
    end

    generate
        if (NARROW_W < DATA_W) begin : g_lane
            logic [NARROW_W-1:0] la, lb;
            assign la = lhs[NARROW_W-1:0];
            assign lb = rhs[NARROW_W-1:0];
            // low-lane flags, sign taken from bit NARROW_W-1
            always_comb begin
                narrow_f.eq     = (la == lb);
                narrow_f.ltu    = (la < lb);
                narrow_f.lts    = ((la ^ N_SIGN) < (lb ^ N_SIGN));
                narrow_f.anybit = |(la & lb);
            end
        end else begin : g_same
            assign narrow_f = wide_f;
        end
    endgenerate

    // pick lane
    always_comb flags = narrow ? narrow_f : wide_f;
endmodule

// File: rtl/brx_cond_decode.sv
// Condition decoder: turns the code and comparator flags into a taken
// decision, the long-displacement select and the end-of-program marker.
// Assumes: reserved codes are never taken.
module brx_cond_decode
    import brx_pkg::*;
(
    input  logic [BRC_W-1:0] cond,
    input  cmp_flags_t       flags,
    output logic             hit,
    output logic             use_long,
    output logic             is_exit
);
    // decision table
    always_comb begin
        hit      = 1'b0;
        use_long = 1'b0;
        is_exit  = 1'b0;
        case (cond)
            BC_JMP:  hit = 1'b1;
            BC_JMPL: begin hit = 1'b1; use_long = 1'b1; end
            BC_EQ:   hit = flags.eq;
            BC_NE:   hit = !flags.eq;
            BC_UGT:  hit = !flags.eq && !flags.ltu;
            BC_UGE:  hit = !flags.ltu;
            BC_ULT:  hit = flags.ltu;
            BC_ULE:  hit = flags.ltu || flags.eq;
            BC_SGT:  hit = !flags.eq && !flags.lts;
            BC_SGE:  hit = !flags.lts;
            BC_SLT:  hit = flags.lts;
            BC_SLE:  hit = flags.lts || flags.eq;
            BC_BTST: hit = flags.anybit;
            BC_EXIT: is_exit = 1'b1;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brx_target_calc.sv
// Target adder: sequential address or sequential address plus the
// sign-extended short or long word displacement.
// Assumes: LDISP_W < PC_W and SDISP_W < LDISP_W.
module brx_target_calc #(
    parameter int PC_W    = 64,
    parameter int SDISP_W = 16,
    parameter int LDISP_W = 32
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [LDISP_W-1:0] disp,
    input  logic               use_long,
    input  logic               take,
    output logic [PC_W-1:0]    next_pc
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] offset;

    // extend the selected displacement field
    always_comb begin
        if (use_long) offset = {{(PC_W-LDISP_W){disp[LDISP_W-1]}}, disp};
        else          offset = {{(PC_W-SDISP_W){disp[SDISP_W-1]}}, disp[SDISP_W-1:0]};
    end

    // form the next address
    always_comb begin
        seq_pc  = pc + PC_ONE;
        next_pc = take ? (seq_pc + offset) : seq_pc;
    end
endmodule

// File: rtl/brx_branch_unit.sv
// Branch resolution unit top: registers the taken flag, next address and
// sticky halt for each accepted request.
// Assumes: one request per cycle; requests while halted are dropped.
module brx_branch_unit
    import brx_pkg::*;
#(
    parameter int PC_W     = 64,
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 32,
    parameter int SDISP_W  = 16,
    parameter int LDISP_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [BRC_W-1:0]   cond,
    input  logic [DATA_W-1:0]  lhs,
    input  logic [DATA_W-1:0]  rhs_reg,
    input  logic [IMM_W-1:0]   imm,
    input  logic               use_imm,
    input  logic               cmp_narrow,
    input  logic [LDISP_W-1:0] disp,
    output logic               res_valid,
    output logic               taken,
    output logic [PC_W-1:0]    next_pc,
    output logic               halted
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] rhs_sel;
    cmp_flags_t        flags;
    logic              cond_hit, use_long, is_exit;
    logic [PC_W-1:0]   pc_calc;
    logic              res_valid_q, taken_q, halted_q;
    logic [PC_W-1:0]   next_pc_q;
    logic              accept;

    brx_operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opmux (
        .rhs_reg(rhs_reg), .imm(imm), .use_imm(use_imm), .rhs(rhs_sel)
    );

    brx_comparator #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmp (
        .lhs(lhs), .rhs(rhs_sel), .narrow(cmp_narrow), .flags(flags)
    );

    brx_cond_decode u_dec (
        .cond(cond), .flags(flags), .hit(cond_hit),
        .use_long(use_long), .is_exit(is_exit)
    );

    brx_target_calc #(.PC_W(PC_W), .SDISP_W(SDISP_W), .LDISP_W(LDISP_W)) u_tgt (
        .pc(cur_pc), .disp(disp), .use_long(use_long),
        .take(cond_hit), .next_pc(pc_calc)
    );

    assign accept = req_valid && !halted_q;

    // result and halt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            taken_q     <= 1'b0;
            halted_q    <= 1'b0;
            next_pc_q   <= '0;
        end else if (accept) begin
            res_valid_q <= 1'b1;
            if (is_exit) begin
                halted_q  <= 1'b1;
                taken_q   <= 1'b0;
                next_pc_q <= cur_pc;
            end else begin
                taken_q   <= cond_hit;
                next_pc_q <= pc_calc;
            end
        end else begin
            res_valid_q <= 1'b0;
            taken_q     <= 1'b0;
        end
    end

    assign res_valid = res_valid_q;
    assign taken     = taken_q;
    assign next_pc   = next_pc_q;
    assign halted    = halted_q;

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> halted_q);

    // R11
    exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cond == BC_EXIT) |=> (halted_q && !taken_q && next_pc_q == $past(cur_pc)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid_q && !taken_q && $stable(next_pc_q)));

    // R2
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_q |-> $past(req_valid));

    // R9
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_q && !taken_q && !$past(halted_q) && !halted_q) |-> (next_pc_q == $past(cur_pc) + PC_ONE));

    // R3
    jmp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cond == BC_JMP || cond == BC_JMPL)) |=> taken_q);

    // R4
    ugt_ult_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.eq && flags.ltu));
endmodule

// File: tb/sim_brx_branch_unit.sv
`timescale 1ns/1ps
module sim_brx_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] cur_pc = '0;
    logic [3:0]  cond = '0;
    logic [63:0] lhs = '0;
    logic [63:0] rhs_reg = '0;
    logic [31:0] imm = '0;
    logic        use_imm = 1'b0;
    logic        cmp_narrow = 1'b0;
    logic [31:0] disp = '0;
    logic        res_valid, taken, halted;
    logic [63:0] next_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 0;
    string cur_tag = "R1";

    // reference state
    bit          m_valid = 0, m_taken = 0, m_halt = 0;
    logic [63:0] m_pc = '0;
    string       m_tag = "R1";

    always #2.5 clk = ~clk;

    brx_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_pc(cur_pc),
        .cond(cond), .lhs(lhs), .rhs_reg(rhs_reg), .imm(imm),
        .use_imm(use_imm), .cmp_narrow(cmp_narrow), .disp(disp),
        .res_valid(res_valid), .taken(taken), .next_pc(next_pc), .halted(halted)
    );

    function automatic bit ref_cond(input logic [3:0] c, input logic [63:0] a,
                                    input logic [63:0] b, input bit nar);
        longint unsigned ua, ub;
        longint sa, sb;
        if (nar) begin
            ua = longint'(a[31:0]); ub = longint'(b[31:0]);
            sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
        end else begin
            ua = a; ub = b; sa = longint'(a); sb = longint'(b);
        end
        case (c)
            4'd0, 4'd1: return 1;
            4'd2:  return ua == ub;
            4'd3:  return ua != ub;
            4'd4:  return ua > ub;
            4'd5:  return ua >= ub;
            4'd6:  return ua < ub;
            4'd7:  return ua <= ub;
            4'd8:  return sa > sb;
            4'd9:  return sa >= sb;
            4'd10: return sa < sb;
            4'd11: return sa <= sb;
            4'd12: return (ua & ub) != 0;
            default: return 0;
        endcase
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic [63:0] b;
        longint off;
        if (!rst_n) begin
            m_valid = 0; m_taken = 0; m_halt = 0; m_pc = '0; m_tag = "R1";
        end else if (req_valid && !m_halt) begin
            m_valid = 1; m_tag = cur_tag;
            if (cond == 4'd13) begin
                m_halt = 1; m_taken = 0; m_pc = cur_pc;
            end else begin
                b = use_imm ? {{32{imm[31]}}, imm} : rhs_reg;
                m_taken = ref_cond(cond, lhs, b, cmp_narrow);
                off = (cond == 4'd1) ? longint'(int'(disp)) : longint'(shortint'(disp[15:0]));
                m_pc = cur_pc + 64'd1 + (m_taken ? off : 64'sd0);
            end
        end else begin
            m_valid = 0; m_taken = 0; m_tag = m_halt ? "R11" : "R2";
        end
        checking = 1;
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (checking) begin
            chk(m_tag, "res_valid", {63'd0, res_valid}, {63'd0, m_valid});
            chk(m_tag, "taken",     {63'd0, taken},     {63'd0, m_taken});
            chk(m_tag, "halted",    {63'd0, halted},    {63'd0, m_halt});
            chk(m_tag, "next_pc",   next_pc,            m_pc);
        end
    end

    task automatic issue(input string tag, input logic [3:0] c, input logic [63:0] pc,
                         input logic [63:0] a, input logic [63:0] b, input logic [31:0] im,
                         input bit ui, input bit nar, input logic [31:0] d);
        @(negedge clk);
        cur_tag = tag; req_valid = 1; cond = c; cur_pc = pc; lhs = a; rhs_reg = b;
        imm = im; use_imm = ui; cmp_narrow = nar; disp = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; cur_tag = "R2";
            lhs = lhs + 64'h77; cur_pc = cur_pc + 64'd9;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state observed over several cycles
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3 equality family
        issue("R3", 4'd2, 64'd100, 64'h1234, 64'h1234, 0, 0, 0, 32'd5);
        issue("R3", 4'd3, 64'd100, 64'h1234, 64'h1234, 0, 0, 0, 32'd5);
        issue("R3", 4'd3, 64'd200, 64'h1, 64'h2, 0, 0, 0, 32'hFFFF_FFF0);
        issue("R3", 4'd14, 64'd300, 64'h0, 64'h0, 0, 0, 0, 32'd7);
        issue("R3", 4'd15, 64'd300, 64'h5, 64'h5, 0, 0, 0, 32'd7);
        // R4 / R5 orderings that disagree between signed and unsigned
        for (int c = 4; c <= 11; c++) begin
            issue(c < 8 ? "R4" : "R5", 4'(c), 64'd40, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 32'd3);
            issue(c < 8 ? "R4" : "R5", 4'(c), 64'd40, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 32'd3);
            issue(c < 8 ? "R4" : "R5", 4'(c), 64'd40, 64'h33, 64'h33, 0, 0, 0, 32'd3);
        end
        // R6 bit test
        issue("R6", 4'd12, 64'd10, 64'hF0, 64'h0F, 0, 0, 0, 32'd2);
        issue("R6", 4'd12, 64'd10, 64'h10, 64'h30, 0, 0, 0, 32'd2);
        issue("R6", 4'd12, 64'd10, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 0, 0, 0, 32'd2);
        // R7 immediate selection and sign extension
        issue("R7", 4'd2, 64'd50, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, 1, 0, 32'd1);
        issue("R7", 4'd2, 64'd50, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 32'd1);
        issue("R7", 4'd2, 64'd50, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 32'd1);
        // R8 narrow compares
        issue("R8", 4'd2, 64'd60, 64'h1_0000_0005, 64'h5, 0, 0, 1, 32'd4);
        issue("R8", 4'd2, 64'd60, 64'h1_0000_0005, 64'h5, 0, 0, 0, 32'd4);
        issue("R8", 4'd10, 64'd60, 64'h0000_0000_8000_0000, 64'h1, 0, 0, 1, 32'd4);
        issue("R8", 4'd6, 64'd60, 64'h0000_0000_8000_0000, 64'h1, 0, 0, 1, 32'd4);
        issue("R8", 4'd8, 64'd60, 64'hFFFF_FFFF_0000_0001, 64'h0, 0, 0, 1, 32'd4);
        issue("R8", 4'd12, 64'd60, 64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0000, 0, 0, 1, 32'd4);
        // R9 short displacements
        issue("R9", 4'd0, 64'd100, 0, 0, 0, 0, 0, 32'h0000_FFFE);
        issue("R9", 4'd0, 64'd100, 0, 0, 0, 0, 0, 32'h1234_0003);
        issue("R9", 4'd0, 64'd5, 0, 0, 0, 0, 0, 32'h0000_8000);
        issue("R9", 4'd0, 64'd0, 0, 0, 0, 0, 0, 32'h0000_FFFE);
        // R10 long displacements
        issue("R10", 4'd1, 64'd100, 0, 0, 0, 0, 0, 32'h0001_0000);
        issue("R10", 4'd1, 64'h1_0000_0000, 0, 0, 0, 0, 0, 32'h8000_0000);
        // R2 idle cycles hold the address
        idle(4);
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [3:0] c;
            logic [63:0] a, b;
            c = 4'($urandom_range(0, 15));
            if (c == 4'd13) c = 4'd2;
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) b[31:0] = a[31:0];
            issue(c < 4 ? "R3" : (c < 8 ? "R4" : (c < 12 ? "R5" : "R6")), c,
                  {$urandom, $urandom}, a, b, $urandom, 1'($urandom), 1'($urandom), $urandom);
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        // R11 end of program and ignored follow-ups
        issue("R11", 4'd13, 64'd777, 0, 0, 0, 0, 0, 32'd9);
        issue("R11", 4'd0, 64'd10, 0, 0, 0, 0, 0, 32'd9);
        issue("R11", 4'd13, 64'd55, 0, 0, 0, 0, 0, 32'd9);
        idle(3);
        // R1 reset clears the halt
        @(negedge clk);
        rst_n = 0; req_valid = 0; cur_tag = "R1";
        repeat (2) @(negedge clk);
        rst_n = 1;
        issue("R3", 4'd2, 64'd8, 64'd1, 64'd1, 0, 0, 0, 32'd2);
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule